// File: doc/BRIEF.md
# Hiccup Restart Supervisor

This block watches a power stage for loss of regulation and enforces a hiccup restart pattern. Its time base is the switching cycle: a one-clock cycle-start pulse marks the start of each switching period. On each cycle start it samples the feedback-enable input. While switching is enabled, a feedback-high sample restarts a fault window. If a full window of consecutive cycle starts passes with feedback low, the block raises a switching-inhibit level for a fixed hold-off of cycle starts. It then releases the inhibit and opens a fresh fault window. The block repeats this on/off pattern until feedback activity returns.

A fault-active flag goes high at the timeout. It stays high until the first feedback-high sample in a later enabled interval. Both interval lengths are parameters counted in cycle starts. The defaults of 5280 and 105600 give about 40 ms and 800 ms at a 132 kHz switching rate. The oscillator and the gate logic sit outside this block.

Top module: `hiccup_supervisor`

## Requirements
- R1: After reset, sw_inhibit and fault_active are both low and a fresh fault window of WIN_CYC cycle starts begins.
- R2: State changes only on clock edges where cyc_start is high. On any other edge both outputs hold and neither interval advances.
- R3: In the enabled interval, WIN_CYC consecutive cycle starts with fb_en low raise both sw_inhibit and fault_active, visible right after the edge of the WIN_CYC-th such cycle start. After fewer such cycle starts, sw_inhibit stays low.
- R4: A cycle start with fb_en high in the enabled interval restarts the window. A timeout then needs WIN_CYC further low cycle starts, whatever point the window had reached.
- R5: The hold-off lasts exactly HOLD_CYC cycle starts. sw_inhibit falls right after the edge of the HOLD_CYC-th cycle start counted after the timeout.
- R6: During the hold-off, fb_en is ignored. sw_inhibit and fault_active both stay high however fb_en is driven.
- R7: When the hold-off ends, a fresh window begins with switching allowed. WIN_CYC further low cycle starts raise sw_inhibit again, so the pattern alternates while the fault persists.
- R8: fault_active stays high after the hold-off ends. It falls right after the edge of the first cycle start with fb_en high in an enabled interval. sw_inhibit high always implies fault_active high.
- R9: fb_en is sampled only on cycle starts. fb_en high on an edge without cyc_start neither restarts the window nor clears fault_active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_start | input | 1 | One-clock pulse at the start of each switching cycle |
| fb_en | input | 1 | Feedback enable, high means the output asks for energy |
| sw_inhibit | output | 1 | High while switching is forced off (hold-off interval) |
| fault_active | output | 1 | High from timeout until feedback activity returns |

## Verification
A window counter that is off by one shows up as an inhibit edge one cycle start early or late. The bench sweeps every kick position in the window, so such a counter is caught within a single window. A wrong hold counter moves the falling inhibit edge, which is caught at the end of the first hold-off. A phase register that lets feedback through during the hold-off shows at once as a low inhibit while the hold-off should still be running. A fault flag that clears on the wrong event is exposed on the first cycle start after release, or on the idle edges between cycle starts.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;

  typedef enum logic {PH_RUN = 1'b0, PH_HOLD = 1'b1} phase_t;

  // counter width able to hold 0 .. lim-1
  function automatic int cnt_width(input int unsigned lim);
    return (lim <= 2) ? 1 : $clog2(lim);
  endfunction

  // true when a count sits on the final value of an interval of length lim
  function automatic logic is_last(input int unsigned cnt, input int unsigned lim);
    return cnt == (lim - 1);
  endfunction

endpackage

// File: rtl/cyc_counter.sv
module cyc_counter
  import hiccup_pkg::*;
#(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic done
);
  localparam int W = cnt_width(LIMIT);

  logic [W-1:0] cnt;
  logic         at_end;

  assign at_end = is_last(32'(cnt), LIMIT);
  assign done   = adv & ~clr & at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (clr)      cnt <= '0;
    else if (adv) begin
      if (at_end)      cnt <= '0;
      else             cnt <= cnt + 1'b1;
    end
  end

  // R5 / R3: count never leaves the interval range
  assert_cnt_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) < LIMIT);

  // R2: without advance or clear the count holds
  assert_cnt_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> $stable(cnt));

endmodule

// File: rtl/phase_ctrl.sv
module phase_ctrl
  import hiccup_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   timeout,
  input  logic   hold_end,
  input  logic   kick,
  input  logic   cyc_start,
  output phase_t phase,
  output logic   fault
);
  phase_t phase_nxt;
  logic   fault_nxt;

  always_comb begin
    phase_nxt = phase;
    unique case (phase)
      PH_RUN:  if (timeout)  phase_nxt = PH_HOLD;
      PH_HOLD: if (hold_end) phase_nxt = PH_RUN;
      default: phase_nxt = PH_RUN;
    endcase
  end

  always_comb begin
    fault_nxt = fault;
    if (timeout)   fault_nxt = 1'b1;
    else if (kick) fault_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_RUN;
      fault <= 1'b0;
    end else begin
      phase <= phase_nxt;
      fault <= fault_nxt;
    end
  end

  // R3: a timeout puts the block into hold with the fault raised
  assert_timeout_enters_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> (phase == PH_HOLD) && fault);

  // R3: hold is only ever entered through a timeout
  assert_hold_only_by_timeout_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase == PH_HOLD) |-> $past(timeout));

  // R6: while holding, nothing but the hold end leaves the hold
  assert_hold_ignores_fb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HOLD && !hold_end) |=> (phase == PH_HOLD));

  // R8: a kick clears the fault flag
  assert_kick_clears_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !fault);

  // R8: inhibit implies fault
  assert_hold_implies_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HOLD) |-> fault);

  // R2: nothing moves between cycle starts
  assert_idle_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_start |=> ($stable(phase) && $stable(fault)));

endmodule

// File: rtl/hiccup_supervisor.sv
module hiccup_supervisor
  import hiccup_pkg::*;
#(
  parameter int unsigned WIN_CYC  = 5280,
  parameter int unsigned HOLD_CYC = 105600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_start,
  input  logic fb_en,
  output logic sw_inhibit,
  output logic fault_active
);
  phase_t phase;
  logic   in_run;
  logic   kick;
  logic   miss;
  logic   timeout;
  logic   hold_tick;
  logic   hold_end;

  assign in_run    = (phase == PH_RUN);
  assign kick      = in_run & cyc_start & fb_en;
  assign miss      = in_run & cyc_start & ~fb_en;
  assign hold_tick = ~in_run & cyc_start;

  // fault window: cleared by feedback or whenever holding
  cyc_counter #(.LIMIT(WIN_CYC)) u_win_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (~in_run | kick),
    .adv   (miss),
    .done  (timeout)
  );

  // hold-off interval: cleared whenever running
  cyc_counter #(.LIMIT(HOLD_CYC)) u_hold_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (in_run),
    .adv   (hold_tick),
    .done  (hold_end)
  );

  phase_ctrl u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .timeout   (timeout),
    .hold_end  (hold_end),
    .kick      (kick),
    .cyc_start (cyc_start),
    .phase     (phase),
    .fault     (fault_active)
  );

  assign sw_inhibit = ~in_run;

  // R9: fb_en without a cycle start changes nothing at the ports
  assert_fb_needs_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_start && fb_en) |=> ($stable(sw_inhibit) && $stable(fault_active)));

  // R7: a hold end reopens switching
  assert_hold_end_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_end |=> !sw_inhibit);

endmodule

// File: tb/hiccup_supervisor_bench.sv
module hiccup_supervisor_bench;
  localparam int WIN  = 6;
  localparam int HOLD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_start = 1'b0;
  logic fb_en = 1'b0;
  logic sw_inhibit, fault_active;
  int   n_chk = 0;
  int   n_bad = 0;
  int   cycles = 0;

  always #5 clk = ~clk;

  hiccup_supervisor #(.WIN_CYC(WIN), .HOLD_CYC(HOLD)) u_hiccup_supervisor (
    .clk          (clk),
    .rst_n        (rst_n),
    .cyc_start    (cyc_start),
    .fb_en        (fb_en),
    .sw_inhibit   (sw_inhibit),
    .fault_active (fault_active)
  );

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cycles);
      report();
    end
  end

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // called at a negedge; drives, lets one posedge pass, returns at next negedge
  task automatic tick(input logic cs, input logic fb);
    cyc_start = cs;
    fb_en     = fb;
    @(negedge clk);
    cyc_start = 1'b0;
    fb_en     = 1'b0;
  endtask

  // serve a full hold-off, checking inhibit on every cycle start (R5, R6)
  task automatic serve_hold(input logic fb_pattern);
    for (int i = 1; i <= HOLD; i++) begin
      tick(1'b1, fb_pattern ^ i[0]);
      chk((i == HOLD) ? "R5" : "R6", sw_inhibit, (i == HOLD) ? 1'b0 : 1'b1, "inhibit during hold-off");
      chk("R8", fault_active, 1'b1, "fault held through hold-off");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", sw_inhibit, 1'b0, "inhibit in reset");
    chk("R1", fault_active, 1'b0, "fault in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", sw_inhibit, 1'b0, "inhibit after reset");
    chk("R1", fault_active, 1'b0, "fault after reset");

    // R3 and R2: low cycle starts with idle edges between them
    for (int i = 1; i <= WIN; i++) begin
      tick(1'b1, 1'b0);
      chk("R3", sw_inhibit, (i == WIN) ? 1'b1 : 1'b0, "inhibit at window count");
      chk("R3", fault_active, (i == WIN) ? 1'b1 : 1'b0, "fault at window count");
      if (i < WIN) begin
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b0);
        chk("R2", sw_inhibit, 1'b0, "idle edges do not advance window");
      end
    end

    // R6 / R5: feedback toggling during hold, with idle edges
    tick(1'b0, 1'b1);
    chk("R2", sw_inhibit, 1'b1, "idle edge keeps hold");
    serve_hold(1'b1);

    // R7: fresh window after release, alternation continues
    for (int i = 1; i <= WIN; i++) begin
      tick(1'b1, 1'b0);
      chk("R7", sw_inhibit, (i == WIN) ? 1'b1 : 1'b0, "second window after release");
      chk("R8", fault_active, 1'b1, "fault stays high without feedback");
    end
    serve_hold(1'b0);

    // R9: feedback without a cycle start does not clear the fault
    tick(1'b0, 1'b1);
    tick(1'b0, 1'b1);
    chk("R9", fault_active, 1'b1, "fb high off cycle start leaves fault");

    // R8: first feedback-high cycle start clears the fault
    tick(1'b1, 1'b1);
    chk("R8", fault_active, 1'b0, "fault cleared by feedback");
    chk("R8", sw_inhibit, 1'b0, "inhibit stays low on kick");

    // R4: sweep every kick position within the window
    for (int k = 0; k < WIN; k++) begin
      for (int i = 0; i < k; i++) tick(1'b1, 1'b0);
      tick(1'b1, 1'b1);
      for (int i = 1; i < WIN; i++) tick(1'b1, 1'b0);
      chk("R4", sw_inhibit, 1'b0, $sformatf("no timeout after kick at %0d", k));
      tick(1'b1, 1'b1);
    end
    for (int i = 1; i <= WIN; i++) tick(1'b1, 1'b0);
    chk("R4", sw_inhibit, 1'b1, "timeout after full window post kicks");
    serve_hold(1'b1);
    tick(1'b1, 1'b1);
    chk("R8", fault_active, 1'b0, "fault cleared after sweep");

    // R9: fb high without cycle start does not restart the window
    for (int i = 1; i < WIN; i++) tick(1'b1, 1'b0);
    tick(1'b0, 1'b1);
    tick(1'b0, 1'b1);
    chk("R9", sw_inhibit, 1'b0, "window near end, still enabled");
    tick(1'b1, 1'b0);
    chk("R9", sw_inhibit, 1'b1, "off-cycle feedback did not restart window");
    chk("R3", fault_active, 1'b1, "fault raised at timeout");

    report();
  end

endmodule